// File: doc/BRIEF.md
# BT.601 Horizontal Line Timer and 4:2:2 Pixel Capture

This block keeps horizontal line timing for an 8-bit multiplexed 4:2:2 video stream sampled at 27 MHz. It also splits the active part of each line into separate chroma and luma bytes. A clock counter numbers the sample positions of a line from 1 up to the line length: 1716 for the 60 Hz standard and 1728 for the 50 Hz standard. After the last position it returns to 1.

There are two sync directions. In slave mode, which is also the state after reset, the sync pin is an input, and each rising edge on it realigns the counter. In master mode the block drives a line sync pulse itself, so the upstream source can send data in step with it. That pulse can be held back by one whole line.

Inside the active window (720 pixels, or 1440 bytes) the bytes arrive in the order Cb, Y, Cr, Y. The block presents each Cb/Y/Cr group with one strobe and the second Y with another. Each strobe carries a pixel index. Mode, standard and delay are static configuration inputs, changed only while reset is asserted.

Top module: `bt601_line_capture`

## Requirements
- R1: Without sync edges the position counter runs freely. It takes every value from 1 to the line length (1716 when `cfg_pal`=0, 1728 when `cfg_pal`=1) and then returns to 1. Each following line's window therefore opens exactly one line length after the previous one.
- R2: In slave mode (`cfg_master`=0), the first sample at which `hsync_in` is seen high after being low has position 1. Later samples count on from there.
- R3: The active window starts with a Cb byte at position 245 (60 Hz) or 265 (50 Hz). It starts one position later when `cfg_sync_dly`=1. The window spans 1440 consecutive positions.
- R4: Within the window the byte phase is (position − start) mod 4: 0 Cb, 1 Y0, 2 Cr, 3 Y1. One clock after a Cr sample, `cc_valid` is high for one cycle. At the same time `cb_out`, `y0_out` and `cr_out` hold the three bytes of that group.
- R5: One clock after a Y1 sample, `y1_valid` is high for one cycle and `y1_out` holds that byte. `y1_valid` always comes in the cycle directly after a `cc_valid`.
- R6: `pix_idx` is 2k with `cc_valid` and 2k+1 with `y1_valid`, where k is the pair number within the line. It runs from 0 to 719 and starts again at 0 in every line.
- R7: Samples outside the window never cause a strobe. `cc_valid` and `y1_valid` are never high together.
- R8: In master mode, `hsync_oe` is high. `hsync_out` is high exactly in the cycles whose position is 1 to 128. `hsync_in` has no effect.
- R9: In master mode with `cfg_hs_line_dly`=1, no pulse appears during the first line after reset. From the second line on, the pulses match R8.
- R10: In slave mode, `hsync_out` and `hsync_oe` stay low.
- R11: While `rst_n` is low, both strobes are low and `pix_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1: block drives line sync; 0: sync is an input |
| cfg_pal | input | 1 | 1: 1728-position line; 0: 1716-position line |
| cfg_sync_dly | input | 1 | Moves the active window one position later |
| cfg_hs_line_dly | input | 1 | Master mode: suppress the pulse during the first line |
| hsync_in | input | 1 | Line sync from upstream (slave mode) |
| hsync_out | output | 1 | Generated line sync, active high (master mode) |
| hsync_oe | output | 1 | Drive enable for the sync pin |
| vid_in | input | 8 | Multiplexed Cb/Y/Cr/Y byte stream |
| cc_valid | output | 1 | Strobe for a Cb/Y0/Cr group |
| cb_out | output | 8 | Blue-difference byte of the group |
| y0_out | output | 8 | First luma byte of the pair |
| cr_out | output | 8 | Red-difference byte of the group |
| y1_valid | output | 1 | Strobe for the second luma byte |
| y1_out | output | 8 | Second luma byte of the pair |
| pix_idx | output | 10 | Pixel index within the line, 0 to 719 |

## Verification
The hardest case to reach is a realignment that falls inside the active window. There the sync edge cuts a half-finished pixel group short, and the index has to start again cleanly with no stray strobe. The stimulus raises `hsync_in` 400 cycles after a free-running line began, which is deep in the window. It then lets the counter run through its natural wrap on its own. The bench models every sample position, so the truncated line, the new line opened by the edge and the later free-running line are all checked byte for byte. This is done for both standards and both window offsets.

// File: rtl/bt601_cap_pkg.sv
// Shared types for the BT.601 line capture block.
// Assumes: byte phase numbering is (position - window start) mod 4.
package bt601_cap_pkg;

    // Position of a byte inside one Cb,Y,Cr,Y group
    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } byte_phase_e;

endpackage

// File: rtl/bt601_line_counter.sv
// Line position counter.
// Counts sample positions 1..line length and then wraps to 1. In slave mode
// a rising edge on the sync input makes the current sample position 1.
// Assumes: configuration is static outside reset; sync input is low in reset.
module bt601_line_counter #(
    parameter int LEN_NTSC = 1716,
    parameter int LEN_PAL  = 1728,
    parameter int CW       = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_master,
    input  logic          cfg_pal,
    input  logic          hsync_in,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cur_cnt,
    output logic          line_wrap
);
    localparam logic [CW-1:0] LEN_N = CW'(LEN_NTSC);
    localparam logic [CW-1:0] LEN_P = CW'(LEN_PAL);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic          hs_prev;
    logic          hs_rise;
    logic [CW-1:0] line_len;

    // Select the line length for the configured standard
    always_comb line_len = cfg_pal ? LEN_P : LEN_N;

    // Detect a low-to-high sync transition (slave mode only)
    always_comb hs_rise = !cfg_master && hsync_in && !hs_prev;

    // Position of the sample taken at this edge
    always_comb cur_cnt = hs_rise ? ONE : cnt_q;

    // Flag the last position of the line
    always_comb line_wrap = (cur_cnt >= line_len);

    // Remember the previous sync level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) hs_prev <= 1'b0;
        else        hs_prev <= hsync_in;
    end

    // Advance the position, wrapping after the last one
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= ONE;
        else if (line_wrap) cnt_q <= ONE;
        else                cnt_q <= cur_cnt + ONE;
    end
endmodule

// File: rtl/bt601_hsync_gen.sv
// Master-mode line sync generator.
// Drives an active-high pulse over positions 1..HS_WIDTH of each line.
// Optionally withholds the pulse until one full line has gone by since reset.
// Assumes: cnt_q is the registered line position from the counter.
module bt601_hsync_gen #(
    parameter int CW       = 11,
    parameter int HS_WIDTH = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_master,
    input  logic          cfg_line_dly,
    input  logic [CW-1:0] cnt_q,
    input  logic          line_wrap,
    output logic          hsync_out,
    output logic          hsync_oe
);
    localparam logic [CW-1:0] HS_LAST = CW'(HS_WIDTH);

    logic line_seen;

    // Record that at least one line end has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n)         line_seen <= 1'b0;
        else if (line_wrap) line_seen <= 1'b1;
    end

    // Pulse during the leading positions, gated by mode and line delay
    always_comb hsync_out = cfg_master && (cnt_q <= HS_LAST) && (!cfg_line_dly || line_seen);

    // Enable the pin driver only in master mode
    always_comb hsync_oe = cfg_master;
endmodule

// File: rtl/bt601_active_window.sv
// Active window decoder.
// From the current sample position, decides whether the byte is active.
// If so, it gives the byte phase and the pixel-pair number.
// Assumes: the window start plus its length fits inside the line.
module bt601_active_window
    import bt601_cap_pkg::*;
#(
    parameter int CW         = 11,
    parameter int PW         = 9,
    parameter int START_NTSC = 245,
    parameter int START_PAL  = 265,
    parameter int ACTIVE_PIX = 720
) (
    input  logic          cfg_pal,
    input  logic          cfg_sync_dly,
    input  logic [CW-1:0] cur_cnt,
    output logic          in_window,
    output byte_phase_e   phase,
    output logic [PW-1:0] pair_idx
);
    localparam logic [CW-1:0] ST_N = CW'(START_NTSC);
    localparam logic [CW-1:0] ST_P = CW'(START_PAL);
    localparam logic [CW-1:0] WIN  = CW'(2 * ACTIVE_PIX);

    logic [CW-1:0] start_pos;
    logic [CW-1:0] offset;
    logic [CW-3:0] quad;

    // First active position for the configured standard and delay
    always_comb start_pos = (cfg_pal ? ST_P : ST_N) + CW'(cfg_sync_dly);

    // Distance of this sample from the window start
    always_comb offset = cur_cnt - start_pos;

    // Window membership: at or after the start and within 2*ACTIVE_PIX bytes
    always_comb in_window = (cur_cnt >= start_pos) && (offset < WIN);

    // Split the offset into a group number and a byte phase
    always_comb begin
        quad     = offset[CW-1:2];
        pair_idx = PW'(quad);
        phase    = byte_phase_e'(offset[1:0]);
    end
endmodule

// File: rtl/bt601_pixel_demux.sv
// Pixel demultiplexer.
// Holds Cb and Y0 until Cr arrives, then strobes the group. It strobes the
// following Y1 on the next clock. Each strobe carries a pixel index.
// Assumes: phase and pair_idx are only meaningful while in_window is high.
module bt601_pixel_demux
    import bt601_cap_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_window,
    input  byte_phase_e   phase,
    input  logic [PW-1:0] pair_idx,
    input  logic [DW-1:0] vid_in,
    output logic          cc_valid,
    output logic [DW-1:0] cb_out,
    output logic [DW-1:0] y0_out,
    output logic [DW-1:0] cr_out,
    output logic          y1_valid,
    output logic [DW-1:0] y1_out,
    output logic [PW:0]   pix_idx
);
    logic [DW-1:0] cb_hold;
    logic [DW-1:0] y0_hold;

    // Stage the first two bytes of each group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cb_hold <= '0;
            y0_hold <= '0;
        end else if (in_window) begin
            if (phase == PH_CB) cb_hold <= vid_in;
            if (phase == PH_Y0) y0_hold <= vid_in;
        end
    end

    // Present the group on Cr and the second luma on Y1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_valid <= 1'b0;
            y1_valid <= 1'b0;
            cb_out   <= '0;
            y0_out   <= '0;
            cr_out   <= '0;
            y1_out   <= '0;
            pix_idx  <= '0;
        end else begin
            cc_valid <= in_window && (phase == PH_CR);
            y1_valid <= in_window && (phase == PH_Y1);
            if (in_window && phase == PH_CR) begin
                cb_out  <= cb_hold;
                y0_out  <= y0_hold;
                cr_out  <= vid_in;
                pix_idx <= {pair_idx, 1'b0};
            end
            if (in_window && phase == PH_Y1) begin
                y1_out  <= vid_in;
                pix_idx <= {pair_idx, 1'b1};
            end
        end
    end
endmodule

// File: rtl/bt601_line_capture.sv
// BT.601 line timer and 4:2:2 pixel capture, top level.
// Chains the line counter, master sync generator, window decoder and
// demultiplexer. Assumes: configuration inputs change only in reset.
module bt601_line_capture #(
    parameter int LEN_NTSC   = 1716,
    parameter int LEN_PAL    = 1728,
    parameter int START_NTSC = 245,
    parameter int START_PAL  = 265,
    parameter int ACTIVE_PIX = 720,
    parameter int HS_WIDTH   = 128,
    parameter int DW         = 8,
    localparam int MAXLEN    = (LEN_PAL > LEN_NTSC) ? LEN_PAL : LEN_NTSC,
    localparam int CW        = $clog2(MAXLEN + 1),
    localparam int IW        = $clog2(ACTIVE_PIX),
    localparam int PW        = IW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_master,
    input  logic          cfg_pal,
    input  logic          cfg_sync_dly,
    input  logic          cfg_hs_line_dly,
    input  logic          hsync_in,
    output logic          hsync_out,
    output logic          hsync_oe,
    input  logic [DW-1:0] vid_in,
    output logic          cc_valid,
    output logic [DW-1:0] cb_out,
    output logic [DW-1:0] y0_out,
    output logic [DW-1:0] cr_out,
    output logic          y1_valid,
    output logic [DW-1:0] y1_out,
    output logic [IW-1:0] pix_idx
);
    import bt601_cap_pkg::*;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cur_cnt;
    logic          line_wrap;
    logic          in_window;
    byte_phase_e   phase;
    logic [PW-1:0] pair_idx;

    bt601_line_counter #(
        .LEN_NTSC (LEN_NTSC),
        .LEN_PAL  (LEN_PAL),
        .CW       (CW)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_master (cfg_master),
        .cfg_pal    (cfg_pal),
        .hsync_in   (hsync_in),
        .cnt_q      (cnt_q),
        .cur_cnt    (cur_cnt),
        .line_wrap  (line_wrap)
    );

    bt601_hsync_gen #(
        .CW       (CW),
        .HS_WIDTH (HS_WIDTH)
    ) u_hsync (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_master   (cfg_master),
        .cfg_line_dly (cfg_hs_line_dly),
        .cnt_q        (cnt_q),
        .line_wrap    (line_wrap),
        .hsync_out    (hsync_out),
        .hsync_oe     (hsync_oe)
    );

    bt601_active_window #(
        .CW         (CW),
        .PW         (PW),
        .START_NTSC (START_NTSC),
        .START_PAL  (START_PAL),
        .ACTIVE_PIX (ACTIVE_PIX)
    ) u_window (
        .cfg_pal      (cfg_pal),
        .cfg_sync_dly (cfg_sync_dly),
        .cur_cnt      (cur_cnt),
        .in_window    (in_window),
        .phase        (phase),
        .pair_idx     (pair_idx)
    );

    bt601_pixel_demux #(
        .DW (DW),
        .PW (PW)
    ) u_demux (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_window (in_window),
        .phase     (phase),
        .pair_idx  (pair_idx),
        .vid_in    (vid_in),
        .cc_valid  (cc_valid),
        .cb_out    (cb_out),
        .y0_out    (y0_out),
        .cr_out    (cr_out),
        .y1_valid  (y1_valid),
        .y1_out    (y1_out),
        .pix_idx   (pix_idx)
    );
endmodule

// File: rtl/bt601_line_capture_chk.sv
// Property checker for bt601_line_capture, attached with bind below.
// Observes ports and the registered line position.
module bt601_line_capture_chk #(
    parameter int LEN_NTSC   = 1716,
    parameter int LEN_PAL    = 1728,
    parameter int ACTIVE_PIX = 720,
    parameter int CW         = 11,
    parameter int IW         = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_master,
    input logic          cfg_pal,
    input logic          hsync_out,
    input logic          hsync_oe,
    input logic          cc_valid,
    input logic          y1_valid,
    input logic [IW-1:0] pix_idx,
    input logic [CW-1:0] cnt_q
);
    localparam logic [CW-1:0] LEN_N = CW'(LEN_NTSC);
    localparam logic [CW-1:0] LEN_P = CW'(LEN_PAL);
    localparam logic [IW-1:0] PMAX  = IW'(ACTIVE_PIX - 1);

    logic [CW-1:0] len;
    always_comb len = cfg_pal ? LEN_P : LEN_N;

    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= CW'(1)) && (cnt_q <= len));

    a_r8_master_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && cnt_q == len) |=> (cnt_q == CW'(1)));

    a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_out) |-> (cnt_q == CW'(1)));

    a_r10_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> (!hsync_out && !hsync_oe));

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(cc_valid && y1_valid));

    a_r5_y1_after_group: assert property (@(posedge clk) disable iff (!rst_n)
        y1_valid |-> $past(cc_valid));

    a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        y1_valid |-> (pix_idx == $past(pix_idx) + IW'(1)));

    a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        pix_idx <= PMAX);
endmodule

bind bt601_line_capture bt601_line_capture_chk #(
    .LEN_NTSC   (LEN_NTSC),
    .LEN_PAL    (LEN_PAL),
    .ACTIVE_PIX (ACTIVE_PIX),
    .CW         (CW),
    .IW         (IW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_master (cfg_master),
    .cfg_pal    (cfg_pal),
    .hsync_out  (hsync_out),
    .hsync_oe   (hsync_oe),
    .cc_valid   (cc_valid),
    .y1_valid   (y1_valid),
    .pix_idx    (pix_idx),
    .cnt_q      (cnt_q)
);

// File: tb/bt601_line_capture_tb_top.sv
// Testbench: models every sample position arithmetically and compares
// strobes, bytes, index and sync against the model at each falling edge.
module bt601_line_capture_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b0, cfg_pal = 1'b0, cfg_sync_dly = 1'b0, cfg_hs_line_dly = 1'b0;
    logic       hsync_in = 1'b0;
    logic       hsync_out, hsync_oe;
    logic [7:0] vid_in = '0;
    logic       cc_valid, y1_valid;
    logic [7:0] cb_out, y0_out, cr_out, y1_out;
    logic [9:0] pix_idx;

    always #2 clk = ~clk;

    bt601_line_capture dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_pal(cfg_pal),
        .cfg_sync_dly(cfg_sync_dly), .cfg_hs_line_dly(cfg_hs_line_dly),
        .hsync_in(hsync_in), .hsync_out(hsync_out), .hsync_oe(hsync_oe),
        .vid_in(vid_in), .cc_valid(cc_valid), .cb_out(cb_out), .y0_out(y0_out),
        .cr_out(cr_out), .y1_valid(y1_valid), .y1_out(y1_out), .pix_idx(pix_idx)
    );

    int n_chk = 0, n_err = 0;
    int bc, seed;
    bit prev_hs, wrapped, line_pulsed;
    bit e_cc, e_y1, e_first;
    logic [7:0] e_cb, e_y0, e_cr, e_y1d, h1, h2;
    int e_idx;

    function automatic int len_f();
        return cfg_pal ? 1728 : 1716;
    endfunction

    function automatic int start_f();
        return (cfg_pal ? 265 : 245) + int'(cfg_sync_dly);
    endfunction

    function automatic logic [7:0] byte_f(int s);
        return 8'(s * 37 + seed * 11 + 5);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        hsync_in = 1'b0;
        vid_in = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!cc_valid, "R11", "cc_valid in reset", int'(cc_valid), 0);
        check(!y1_valid, "R11", "y1_valid in reset", int'(y1_valid), 0);
        check(pix_idx == 0, "R11", "pix_idx in reset", int'(pix_idx), 0);
        if (!cfg_master) check(!hsync_out, "R11", "hsync_out in reset", int'(hsync_out), 0);
        rst_n = 1'b1;
        bc = 1; prev_hs = 0; wrapped = 0; line_pulsed = 0;
        e_cc = 0; e_y1 = 0; e_first = 0; h1 = '0; h2 = '0;
    endtask

    // One clock: check outputs of the previous edge, then drive the next sample
    task automatic cycle(bit hs);
        int s, st, ph, k;
        logic [7:0] d;
        bit exp_hs;
        string ftag;
        ftag = e_cc ? "R4" : (e_y1 ? "R5" : "R7");
        check(cc_valid == e_cc, ftag, "cc_valid", int'(cc_valid), int'(e_cc));
        check(y1_valid == e_y1, ftag, "y1_valid", int'(y1_valid), int'(e_y1));
        if (e_cc && e_first) begin
            check(cc_valid, "R3", "first group at window start", int'(cc_valid), 1);
            check(cc_valid, line_pulsed ? "R2" : "R1", "line alignment", int'(cc_valid), 1);
        end
        if (e_cc) begin
            check(cb_out == e_cb, "R4", "cb_out", int'(cb_out), int'(e_cb));
            check(y0_out == e_y0, "R4", "y0_out", int'(y0_out), int'(e_y0));
            check(cr_out == e_cr, "R4", "cr_out", int'(cr_out), int'(e_cr));
            check(pix_idx == 10'(e_idx), "R6", "even pix_idx", int'(pix_idx), e_idx);
        end
        if (e_y1) begin
            check(y1_out == e_y1d, "R5", "y1_out", int'(y1_out), int'(e_y1d));
            check(pix_idx == 10'(e_idx), "R6", "odd pix_idx", int'(pix_idx), e_idx);
        end
        exp_hs = cfg_master && (bc <= 128) && (!cfg_hs_line_dly || wrapped);
        ftag = cfg_master ? (cfg_hs_line_dly ? "R9" : "R8") : "R10";
        check(hsync_out == exp_hs, ftag, "hsync_out", int'(hsync_out), int'(exp_hs));
        check(hsync_oe == cfg_master, ftag, "hsync_oe", int'(hsync_oe), int'(cfg_master));

        if (!cfg_master && hs && !prev_hs) begin
            s = 1;
            line_pulsed = 1;
        end else begin
            s = bc;
        end
        d = byte_f(s);
        hsync_in = hs;
        vid_in = d;
        st = start_f();
        e_cc = 0; e_y1 = 0; e_first = 0;
        if (s >= st && s < st + 1440) begin
            ph = (s - st) % 4;
            k = (s - st) / 4;
            if (ph == 2) begin
                e_cc = 1; e_cb = h2; e_y0 = h1; e_cr = d; e_idx = 2 * k; e_first = (k == 0);
            end
            if (ph == 3) begin
                e_y1 = 1; e_y1d = d; e_idx = 2 * k + 1;
            end
        end
        h2 = h1; h1 = d; prev_hs = hs;
        if (s == len_f()) begin
            bc = 1; wrapped = 1; line_pulsed = 0;
        end else begin
            bc = s + 1;
        end
        @(negedge clk);
    endtask

    // Slave run: sync pulse of plen cycles beginning at cycle p (p<0: none)
    task automatic run_slave(int n, int p, int plen);
        for (int i = 0; i < n; i++) cycle(i >= p && p >= 0 && i < p + plen);
    endtask

    // Master run: sync input toggles with junk that must be ignored (R8)
    task automatic run_master(int n);
        for (int i = 0; i < n; i++) cycle((i % 7) == 0);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        seed = 0;
        @(negedge clk);
        for (int cfg = 0; cfg < 4; cfg++) begin
            cfg_master = 1'b0;
            cfg_pal = cfg[1];
            cfg_sync_dly = cfg[0];
            cfg_hs_line_dly = 1'b0;
            seed = cfg + 1;
            do_reset();
            // R1 free-run first window, R2 realign inside the window
            run_slave(len_f() + 300, 400, 8);
            // R1 natural wraps afterwards
            run_slave(2 * len_f(), -1, 0);
        end
        for (int m = 0; m < 2; m++) begin
            cfg_master = 1'b1;
            cfg_pal = m[0];
            cfg_sync_dly = m[0];
            cfg_hs_line_dly = m[0];
            seed = 10 + m;
            do_reset();
            run_master(2 * len_f() + 200);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule